// File: doc/BRIEF.md
# Rotating Register-Window File

This block is an integer register file for a load/store processor core. Software sees 32 architectural registers, addressed by 5-bit numbers, but they are drawn from a larger physical pool. The pool holds eight shared globals plus seven private banks of sixteen registers. Each bank is split into an incoming group and a local group.

A current window pointer picks which banks back the windowed registers. A procedure call issues a save, which moves the pointer one window down, modulo the window count. The caller's outgoing registers then become the callee's incoming registers, with no copying. A return issues a restore, which moves the pointer back up. The pointer wraps like a circular buffer.

A window-invalid mask marks the windows that must not be entered. A save or restore whose destination window is marked does not move the pointer. Instead it raises a one-cycle spill or fill trap, so that software can move a window to or from memory.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, both trap outputs are low, and every architectural register in every window reads zero.
- R2: Architectural register 0 always reads zero. A write to it is discarded.
- R3: Architectural registers 1 to 7 are the same physical registers in every window.
- R4: Architectural registers 8 to 23 belong to the current window. A value written there is not visible through those numbers in any other window.
- R5: After a save, the values previously read as registers 24 to 31 read as registers 8 to 15. A following restore reads them again as registers 24 to 31.
- R6: A save that does not trap sets the pointer to (p+6) mod 7, so 0 goes to 6. A restore that does not trap sets the pointer to (p+1) mod 7, so 6 goes to 0. The new value appears on `winPtr` one cycle after the strobe.
- R7: A save whose destination window has its mask bit set (`wim` bit index = destination pointer) leaves the pointer unchanged. `spillTrap` is high for exactly the following cycle.
- R8: A restore whose destination window has its mask bit set leaves the pointer unchanged. `fillTrap` is high for exactly the following cycle.
- R9: When save and restore are asserted in the same cycle, neither takes effect: the pointer is unchanged and no trap is raised.
- R10: When a read port addresses the register being written in the same cycle, it returns the new write data. This holds for any nonzero number, and register 0 still reads zero.
- R11: Reads are combinational from the current pointer and contents. A write is applied at the clock edge, through the pointer value held in that cycle, before any move of the pointer takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Architectural register to write |
| wrData | input | 32 | Write data |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | 32 | Read port B data |
| save | input | 1 | Move the window one step down (call) |
| restore | input | 1 | Move the window one step up (return) |
| wim | input | 7 | Window-invalid mask, one bit per window |
| spillTrap | output | 1 | Save refused, pulse |
| fillTrap | output | 1 | Restore refused, pulse |
| winPtr | output | 3 | Current window pointer |

## Verification
A corrupted pointer shows up on `winPtr` on the cycle after the strobe. It also shows up at once on the read ports, because every windowed read then lands in the wrong bank. A wrong bank mapping, or a wrong wrap of the outgoing group, stays hidden until a register written in one window is read back from a neighbouring window. For that reason the stimulus saves and restores often between writes and reads. A missed or spurious trap is visible on the trap outputs one cycle after the strobe, paired with an unchanged pointer.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int NUM_RD = 2;

  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic              wrCommit;  // write accepted (nonzero target)
    logic [NUM_RD-1:0] bypass;    // read port i sees this cycle's write
  } rwin_strobe_t;
endpackage

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN = 7,
  parameter int AW   = 5,
  localparam int PW  = $clog2(NWIN)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [AW-1:0]               wrAddr,
  input  logic [NUM_RD-1:0][AW-1:0]   rdAddr,
  input  logic                        save,
  input  logic                        restore,
  input  logic [NWIN-1:0]             wim,
  output logic [PW-1:0]               winPtr,
  output logic                        spillTrap,
  output logic                        fillTrap,
  output rwin_strobe_t                strobe
);
  logic [PW-1:0] ptrDec, ptrInc;
  logic doSave, doRestore, saveBlocked, restoreBlocked;

  assign ptrDec = (winPtr == '0) ? PW'(NWIN - 1) : winPtr - PW'(1);
  assign ptrInc = (winPtr == PW'(NWIN - 1)) ? '0 : winPtr + PW'(1);

  // Opposite strobes in one cycle cancel each other.
  assign doSave         = save & ~restore;
  assign doRestore      = restore & ~save;
  assign saveBlocked    = wim[ptrDec];
  assign restoreBlocked = wim[ptrInc];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winPtr    <= '0;
      spillTrap <= 1'b0;
      fillTrap  <= 1'b0;
    end else begin
      spillTrap <= doSave & saveBlocked;
      fillTrap  <= doRestore & restoreBlocked;
      if (doSave && !saveBlocked)
        winPtr <= ptrDec;
      else if (doRestore && !restoreBlocked)
        winPtr <= ptrInc;
    end
  end

  always_comb begin
    strobe.wrCommit = wrEn && (wrAddr != '0);
    for (int i = 0; i < NUM_RD; i++)
      strobe.bypass[i] = strobe.wrCommit && (rdAddr[i] == wrAddr);
  end
endmodule

// File: rtl/rwin_dpath.sv
module rwin_dpath
  import rwin_pkg::*;
#(
  parameter int NWIN = 7,
  parameter int GRP  = 8,   // registers per group, power of two
  parameter int DW   = 32,
  localparam int AW    = $clog2(4 * GRP),
  localparam int PW    = $clog2(NWIN),
  localparam int NPHYS = GRP + NWIN * 2 * GRP,
  localparam int PIW   = $clog2(NPHYS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PW-1:0]               winPtr,
  input  rwin_strobe_t                strobe,
  input  logic [AW-1:0]               wrAddr,
  input  logic [DW-1:0]               wrData,
  input  logic [NUM_RD-1:0][AW-1:0]   rdAddr,
  output logic [NUM_RD-1:0][DW-1:0]   rdData
);
  logic [DW-1:0] bank [NPHYS];

  // Groups: 0 globals, 1 incoming, 2 local, 3 outgoing (= next window's incoming).
  function automatic logic [PIW-1:0] physOf(input logic [AW-1:0] a,
                                            input logic [PW-1:0] p);
    int grp, off, win, idx;
    grp = int'(a) / GRP;
    off = int'(a) % GRP;
    win = int'(p);
    case (grp)
      0:       idx = off;
      1:       idx = GRP + win * 2 * GRP + off;
      2:       idx = GRP + win * 2 * GRP + GRP + off;
      default: idx = GRP + ((win + NWIN - 1) % NWIN) * 2 * GRP + off;
    endcase
    return PIW'(idx);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPHYS; i++) bank[i] <= '0;
    end else if (strobe.wrCommit) begin
      bank[physOf(wrAddr, winPtr)] <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : gRead
    always_comb begin
      if (rdAddr[g] == '0)
        rdData[g] = '0;
      else if (strobe.bypass[g])
        rdData[g] = wrData;
      else
        rdData[g] = bank[physOf(rdAddr[g], winPtr)];
    end
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int NWIN = 7,
  parameter int GRP  = 8,
  parameter int DW   = 32,
  localparam int AW  = $clog2(4 * GRP),
  localparam int PW  = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [DW-1:0]   wrData,
  input  logic [AW-1:0]   rdAddrA,
  output logic [DW-1:0]   rdDataA,
  input  logic [AW-1:0]   rdAddrB,
  output logic [DW-1:0]   rdDataB,
  input  logic            save,
  input  logic            restore,
  input  logic [NWIN-1:0] wim,
  output logic            spillTrap,
  output logic            fillTrap,
  output logic [PW-1:0]   winPtr
);
  logic [NUM_RD-1:0][AW-1:0] rdAddr;
  logic [NUM_RD-1:0][DW-1:0] rdData;
  rwin_strobe_t              strobe;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  rwin_ctrl #(.NWIN(NWIN), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .save(save), .restore(restore), .wim(wim), .winPtr(winPtr),
    .spillTrap(spillTrap), .fillTrap(fillTrap), .strobe(strobe)
  );

  rwin_dpath #(.NWIN(NWIN), .GRP(GRP), .DW(DW)) uDpath (
    .clk(clk), .rstN(rstN), .winPtr(winPtr), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int NWIN = 7,
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int PW   = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [AW-1:0]   wrAddr,
  input logic [DW-1:0]   wrData,
  input logic [AW-1:0]   rdAddrA,
  input logic [DW-1:0]   rdDataA,
  input logic            save,
  input logic            restore,
  input logic [NWIN-1:0] wim,
  input logic            spillTrap,
  input logic            fillTrap,
  input logic [PW-1:0]   winPtr
);
  logic [PW-1:0] dstDown, dstUp;
  assign dstDown = (winPtr == '0) ? PW'(NWIN - 1) : winPtr - PW'(1);
  assign dstUp   = (winPtr == PW'(NWIN - 1)) ? '0 : winPtr + PW'(1);

  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0));

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(winPtr) < NWIN);

  assert_save_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    (save && !restore && !wim[dstDown]) |=> (winPtr == $past(dstDown)));

  assert_restore_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    (restore && !save && !wim[dstUp]) |=> (winPtr == $past(dstUp)));

  assert_spill_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (save && !restore && wim[dstDown]) |=> (spillTrap && $stable(winPtr)));

  assert_fill_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (restore && !save && wim[dstUp]) |=> (fillTrap && $stable(winPtr)));

  assert_both_cancel_R9: assert property (@(posedge clk) disable iff (!rstN)
    (save && restore) |=> (!spillTrap && !fillTrap && $stable(winPtr)));

  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && rdAddrA == wrAddr) |-> (rdDataA == wrData));
endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .AW(AW), .DW(DW), .PW(PW)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .save(save), .restore(restore),
  .wim(wim), .spillTrap(spillTrap), .fillTrap(fillTrap), .winPtr(winPtr)
);

// File: tb/tb_rwin_regfile.sv
`timescale 1ns/1ps
module tb_rwin_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0;
  logic [31:0] rdDataA, rdDataB;
  logic        save = 1'b0, restore = 1'b0;
  logic [6:0]  wim = '0;
  logic        spillTrap, fillTrap;
  logic [2:0]  winPtr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [31:0] model [120];
  int mPtr;

  always #2.5 clk = ~clk;

  rwin_regfile dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .save(save), .restore(restore), .wim(wim), .spillTrap(spillTrap),
    .fillTrap(fillTrap), .winPtr(winPtr)
  );

  function automatic int mapReg(int a, int w);
    if (a < 8)  return a;
    if (a < 16) return 8 + w * 16 + (a - 8);
    if (a < 24) return 16 + w * 16 + (a - 16);
    return 8 + ((w + 6) % 7) * 16 + (a - 24);
  endfunction

  function automatic logic [31:0] expRead(int a);
    if (a == 0) return 32'd0;
    if (wrEn && int'(wrAddr) == a) return wrData;
    return model[mapReg(a, mPtr)];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, check reads, apply model at posedge, check state.
  task automatic cyc(string tag, bit we, int wa, logic [31:0] wd, int ra, int rb,
                     bit sv, bit rs, logic [6:0] wm);
    int dn, up;
    bit expSpill, expFill;
    @(negedge clk);
    wrEn = we; wrAddr = 5'(wa); wrData = wd; rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    save = sv; restore = rs; wim = wm;
    #1;
    chk({tag, " R10/R11 portA"}, rdDataA, expRead(ra));
    chk({tag, " R10/R11 portB"}, rdDataB, expRead(rb));
    dn = (mPtr + 6) % 7;
    up = (mPtr + 1) % 7;
    expSpill = sv && !rs && wm[dn];
    expFill  = rs && !sv && wm[up];
    @(posedge clk);
    if (we && wa != 0) model[mapReg(wa, mPtr)] = wd;
    if (sv && !rs && !wm[dn]) mPtr = dn;
    else if (rs && !sv && !wm[up]) mPtr = up;
    #1;
    chk({tag, " R6 ptr"}, 32'(winPtr), 32'(mPtr));
    chk({tag, " R7 spill"}, 32'(spillTrap), 32'(expSpill));
    chk({tag, " R8 fill"}, 32'(fillTrap), 32'(expFill));
  endtask

  task automatic rd(string tag, int a, logic [31:0] exp);
    cyc(tag, 0, 0, 0, a, a, 0, 0, 0);
    chk({tag, " directed"}, rdDataA, exp);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 120; i++) model[i] = '0;
    mPtr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ptr", 32'(winPtr), 0);
    chk("R1 reset spill", 32'(spillTrap), 0);
    chk("R1 reset fill", 32'(fillTrap), 0);
    @(negedge clk); rstN = 1'b1;
    for (int a = 0; a < 32; a++) rd("R1 reset contents", a, 0);

    // R2: register 0 discards writes
    cyc("R2 write r0", 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    rd("R2 r0 after write", 0, 0);

    // R3/R4/R5 directed
    cyc("R3 write global", 1, 5, 32'h0000_0555, 0, 0, 0, 0, 0);
    cyc("R4 write local", 1, 17, 32'h0000_1717, 0, 0, 0, 0, 0);
    cyc("R5 write out", 1, 26, 32'h0000_2626, 0, 0, 0, 0, 0);
    cyc("R6 save wrap", 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 wrap 0 to 6", 32'(winPtr), 6);
    rd("R5 out seen as in", 10, 32'h0000_2626);
    rd("R3 global shared", 5, 32'h0000_0555);
    rd("R4 local private", 17, 0);
    cyc("R6 restore wrap", 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R6 wrap 6 to 0", 32'(winPtr), 0);
    rd("R5 back as out", 26, 32'h0000_2626);
    rd("R4 local restored", 17, 32'h0000_1717);

    // R7/R8: traps hold pointer
    cyc("R7 spill", 0, 0, 0, 0, 0, 1, 0, 7'b100_0000);
    chk("R7 spill pulse", 32'(spillTrap), 1);
    cyc("R7 spill clears", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 one cycle", 32'(spillTrap), 0);
    cyc("R8 fill", 0, 0, 0, 0, 0, 0, 1, 7'b000_0010);
    chk("R8 fill pulse", 32'(fillTrap), 1);
    chk("R8 ptr held", 32'(winPtr), 0);
    // R9: both strobes cancel
    cyc("R9 both", 0, 0, 0, 0, 0, 1, 1, 7'b111_1111);
    chk("R9 no move", 32'(winPtr), 0);
    // R10: bypass on both ports
    cyc("R10 bypass", 1, 20, 32'hA5A5_0020, 20, 20, 0, 0, 0);
    // R11: write during save lands in old window
    cyc("R11 write with save", 1, 12, 32'h0000_1212, 0, 0, 1, 0, 0);
    rd("R11 new window r12", 12, 0);
    cyc("R11 back", 0, 0, 0, 0, 0, 0, 1, 0);
    rd("R11 old window r12", 12, 32'h0000_1212);

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      int r;
      bit sv, rs;
      logic [6:0] wm;
      r  = int'($urandom % 12);
      sv = (r == 0) || (r == 1) || (r == 11);
      rs = (r == 2) || (r == 3) || (r == 11);
      wm = ($urandom % 5 == 0) ? 7'($urandom) : 7'd0;
      cyc("R3/R4/R5 random", ($urandom % 3) != 0, int'($urandom % 32), $urandom,
          int'($urandom % 32), int'($urandom % 32), sv, rs, wm);
    end

    finish();
  end
endmodule